// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block serves the transmit side of an Ethernet controller. Software fills a ring of 8-byte buffer descriptors in shared memory, sets the ring base once, and pulses a kick strobe. While the controller is enabled, the block reads one descriptor after another through a simple word-addressed memory master. It gathers the bytes of every buffer owned by hardware into a local frame store. It hands each descriptor back to software by clearing its ready bit. When a descriptor marked as the end of a frame has been consumed, it plays the gathered frame out on a byte stream with start and end markers.

A frame may be spread over several descriptors. A per-descriptor wrap flag sends the walk back to the ring base. Frames that grow past a fixed cap are cut to the cap and flagged rather than dropped. The walk stops at the first descriptor still owned by software, or after a fixed number of descriptors. Either way, the next kick resumes from that point. One-cycle event strobes report each consumed buffer, each finished frame and each truncation.

Top module: `txbd_walker`

## Requirements
- R1: A kick is accepted only while `enable` is high. A kick with `enable` low causes no memory access and leaves `busy` low.
- R2: A descriptor occupies two memory words at word address P. Word P holds the flags in bits 31:16 and the byte length in bits 15:0. Word P+1 holds the buffer byte address. In the flags, bit 15 is ready, bit 13 is wrap and bit 11 is end-of-frame. Buffer bytes are big-endian: byte address A lies in word A>>2, at bits 31:24 when A mod 4 is 0, down to bits 7:0 when A mod 4 is 3. Buffers may start at any byte.
- R3: The walk stops at the first descriptor whose ready bit is clear. The next accepted kick starts at that same descriptor.
- R4: After a consumed descriptor, the next descriptor is at the ring base if its wrap bit is set, and at P+2 words otherwise.
- R5: Once a frame holds FRAME_MAX bytes (default 2032), bytes from further buffers are dropped. The descriptor that first exceeds the cap pulses `ev_babble`.
- R6: Each consumed descriptor has word P rewritten with only the ready bit cleared. Word P+1 is not written.
- R7: Every consumed descriptor pulses `ev_txb`. An end-of-frame descriptor also pulses `ev_txf` and streams the gathered bytes in order, with `out_sof` on the first beat and `out_eof` on the last. A frame of zero bytes produces the pulses but no beats.
- R8: One walk consumes at most MAX_DESC descriptors (default 1024). It then stops, with the following descriptor as the resume point.
- R9: While idle, writing the ring base takes byte address bits 31:2 as the word address and loads the descriptor pointer as well. While busy, such a write is ignored.
- R10: A kick accepted during a walk is remembered, and it starts one more walk after the current walk ends.
- R11: `busy` rises in the cycle after an accepted kick and stays high until the walk stops. Stream beats occur only while `busy` is high.
- R12: Each walk starts with an empty frame. Bytes of a frame left open when a walk stops are discarded and never streamed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Controller enable; gates kick acceptance |
| kick | input | 1 | One-cycle transmit kick strobe |
| base_wr | input | 1 | Ring base write strobe |
| base_wdata | input | 32 | Ring base byte address |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Request completion |
| out_valid | output | 1 | Frame byte valid |
| out_data | output | 8 | Frame byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| ev_txb | output | 1 | Buffer consumed pulse |
| ev_txf | output | 1 | Frame finished pulse |
| ev_babble | output | 1 | Frame truncated pulse |

## Verification
The hardest behaviour to reach from the ports is a kick that arrives while a walk is still running. Such a kick must be remembered across the idle cycle between walks. The bench reaches it by lowering the descriptor limit to four and placing six ready single-byte frames in the ring. It then pulses a second kick a few cycles after the first, and expects all six frames with no third kick. Truncation is reached the same way, through a small frame cap. The bench writes the ring base in the middle of a walk that ends on a wrap descriptor. This shows the ignored write: the walk returns to the old base.

// File: rtl/txw_pkg.sv
package txw_pkg;

    // Descriptor flag bit positions inside the 16-bit flags field
    localparam int FLG_READY = 15;
    localparam int FLG_WRAP  = 13;
    localparam int FLG_LAST  = 11;

    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
    } desc_hdr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_HDR,
        ST_RD_PTR,
        ST_COPY,
        ST_WBACK,
        ST_EMIT,
        ST_ADV
    } walk_st_e;

    // Pick a big-endian byte lane out of a memory word
    function automatic logic [7:0] be_lane(input logic [31:0] w, input logic [1:0] off);
        logic [7:0] b;
        case (off)
            2'd0:    b = w[31:24];
            2'd1:    b = w[23:16];
            2'd2:    b = w[15:8];
            default: b = w[7:0];
        endcase
        return b;
    endfunction

    // Header image written back: ownership handed to software
    function automatic logic [31:0] release_hdr(input desc_hdr_t h);
        desc_hdr_t r;
        r = h;
        r.flags[FLG_READY] = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/txw_frame_buf.sv
module txw_frame_buf #(
    parameter int DEPTH = 2032,
    parameter int IDX_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    assign rd_data = (int'(rd_idx) < DEPTH) ? store[rd_idx] : 8'h00;

    // R5: gathering never writes past the frame cap
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (int'(wr_idx) < DEPTH));

endmodule

// File: rtl/txw_ring_ptr.sv
module txw_ring_ptr #(
    parameter int BA_W     = 32,
    parameter int MAX_DESC = 1024,
    localparam int WA_W    = BA_W - 2,
    localparam int DC_W    = $clog2(MAX_DESC + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            idle,
    input  logic            base_wr,
    input  logic [BA_W-1:0] base_wdata,
    input  logic            walk_start,
    input  logic            adv,
    input  logic            wrap,
    output logic [WA_W-1:0] ptr,
    output logic            limit_hit
);

    logic [WA_W-1:0] base_q;
    logic [DC_W-1:0] dcnt;
    logic            unused_lsb;

    assign unused_lsb = ^base_wdata[1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ptr    <= '0;
        end else if (base_wr && idle) begin
            base_q <= base_wdata[BA_W-1:2];
            ptr    <= base_wdata[BA_W-1:2];
        end else if (adv) begin
            ptr <= wrap ? base_q : ptr + WA_W'(2);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dcnt <= '0;
        end else if (walk_start) begin
            dcnt <= '0;
        end else if (adv) begin
            dcnt <= dcnt + DC_W'(1);
        end
    end

    assign limit_hit = (dcnt == DC_W'(MAX_DESC - 1));

    // R8: the per-walk count never runs past the limit
    p_desc_limit_r8: assert property (@(posedge clk) disable iff (rst)
        adv |-> (int'(dcnt) < MAX_DESC));

    // R9: a base write while busy leaves the pointer alone
    p_base_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (base_wr && !idle && !adv) |=> $stable(ptr));

endmodule

// File: rtl/txbd_walker.sv
module txbd_walker
    import txw_pkg::*;
#(
    parameter int FRAME_MAX = 2032,
    parameter int MAX_DESC  = 1024,
    parameter int BA_W      = 32,
    localparam int WA_W     = BA_W - 2,
    localparam int CNT_W    = $clog2(FRAME_MAX + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable,
    input  logic            kick,
    input  logic            base_wr,
    input  logic [31:0]     base_wdata,
    output logic            busy,
    output logic            mem_req,
    output logic            mem_we,
    output logic [29:0]     mem_addr,
    output logic [31:0]     mem_wdata,
    input  logic [31:0]     mem_rdata,
    input  logic            mem_ack,
    output logic            out_valid,
    output logic [7:0]      out_data,
    output logic            out_sof,
    output logic            out_eof,
    output logic            ev_txb,
    output logic            ev_txf,
    output logic            ev_babble
);

    walk_st_e        st;
    desc_hdr_t       hdr;
    logic [BA_W-1:0] baddr;
    logic [15:0]     rem;
    logic [CNT_W-1:0] fcnt;
    logic [CNT_W-1:0] eidx;
    logic [31:0]     cache_w;
    logic [WA_W-1:0] cache_a;
    logic            cache_v;
    logic            pend;

    logic [WA_W-1:0] ptr;
    logic            limit_hit;
    logic            walk_start;
    logic            adv;
    logic            hit;
    logic            fb_we;
    logic [7:0]      fb_rd;
    logic [16:0]     space17;
    logic [16:0]     len17;
    logic            over;
    logic [15:0]     take;

    assign walk_start = (st == ST_IDLE) && enable && (kick || pend);
    assign adv        = (st == ST_ADV);
    assign busy       = (st != ST_IDLE);
    assign hit        = cache_v && (cache_a == baddr[BA_W-1:2]);
    assign fb_we      = (st == ST_COPY) && (rem != 16'd0) && hit;

    // Bytes this descriptor may still add before the cap
    assign space17 = 17'(CNT_W'(FRAME_MAX) - fcnt);
    assign len17   = {1'b0, hdr.len};
    assign over    = (len17 > space17);
    assign take    = over ? space17[15:0] : hdr.len;

    txw_ring_ptr #(
        .BA_W     (BA_W),
        .MAX_DESC (MAX_DESC)
    ) ring_i (
        .clk        (clk),
        .rst        (rst),
        .idle       (st == ST_IDLE),
        .base_wr    (base_wr),
        .base_wdata (base_wdata[BA_W-1:0]),
        .walk_start (walk_start),
        .adv        (adv),
        .wrap       (hdr.flags[FLG_WRAP]),
        .ptr        (ptr),
        .limit_hit  (limit_hit)
    );

    txw_frame_buf #(
        .DEPTH (FRAME_MAX),
        .IDX_W (CNT_W)
    ) fbuf_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (fb_we),
        .wr_idx  (fcnt),
        .wr_data (be_lane(cache_w, baddr[1:0])),
        .rd_idx  (eidx),
        .rd_data (fb_rd)
    );

    // Memory master request decode
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (st)
            ST_RD_HDR: mem_req = 1'b1;
            ST_RD_PTR: begin
                mem_req  = 1'b1;
                mem_addr = ptr + WA_W'(1);
            end
            ST_COPY: begin
                mem_req  = (rem != 16'd0) && !hit;
                mem_addr = baddr[BA_W-1:2];
            end
            ST_WBACK: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = release_hdr(hdr);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            hdr       <= '0;
            baddr     <= '0;
            rem       <= '0;
            fcnt      <= '0;
            eidx      <= '0;
            cache_w   <= '0;
            cache_a   <= '0;
            cache_v   <= 1'b0;
            pend      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            ev_txb    <= 1'b0;
            ev_txf    <= 1'b0;
            ev_babble <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_eof   <= 1'b0;
            ev_txb    <= 1'b0;
            ev_txf    <= 1'b0;
            ev_babble <= 1'b0;
            if (kick && enable && st != ST_IDLE) begin
                pend <= 1'b1;
            end
            case (st)
                ST_IDLE: begin
                    if (walk_start) begin
                        pend <= 1'b0;
                        fcnt <= '0;
                        st   <= ST_RD_HDR;
                    end
                end
                ST_RD_HDR: begin
                    if (mem_ack) begin
                        hdr <= mem_rdata;
                        st  <= mem_rdata[16 + FLG_READY] ? ST_RD_PTR : ST_IDLE;
                    end
                end
                ST_RD_PTR: begin
                    if (mem_ack) begin
                        baddr     <= mem_rdata[BA_W-1:0];
                        rem       <= take;
                        ev_babble <= over;
                        cache_v   <= 1'b0;
                        st        <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (rem == 16'd0) begin
                        st <= ST_WBACK;
                    end else if (hit) begin
                        fcnt  <= fcnt + CNT_W'(1);
                        baddr <= baddr + BA_W'(1);
                        rem   <= rem - 16'd1;
                    end else if (mem_ack) begin
                        cache_w <= mem_rdata;
                        cache_a <= baddr[BA_W-1:2];
                        cache_v <= 1'b1;
                    end
                end
                ST_WBACK: begin
                    if (mem_ack) begin
                        ev_txb <= 1'b1;
                        if (hdr.flags[FLG_LAST]) begin
                            ev_txf <= 1'b1;
                            if (fcnt != '0) begin
                                eidx <= '0;
                                st   <= ST_EMIT;
                            end else begin
                                st <= ST_ADV;
                            end
                        end else begin
                            st <= ST_ADV;
                        end
                    end
                end
                ST_EMIT: begin
                    out_valid <= 1'b1;
                    out_data  <= fb_rd;
                    out_sof   <= (eidx == '0);
                    out_eof   <= (eidx == fcnt - CNT_W'(1));
                    if (eidx == fcnt - CNT_W'(1)) begin
                        fcnt <= '0;
                        st   <= ST_ADV;
                    end else begin
                        eidx <= eidx + CNT_W'(1);
                    end
                end
                ST_ADV: begin
                    st <= limit_hit ? ST_IDLE : ST_RD_HDR;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R1: no memory traffic while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req);

    // R1: a kick with the controller disabled starts nothing
    p_disabled_kick_r1: assert property (@(posedge clk) disable iff (rst)
        (!busy && kick && !enable && !pend) |=> !busy);

    // R6: written-back headers never carry the ready bit
    p_wb_ready_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !mem_wdata[16 + FLG_READY]);

    // R5: the frame count stays within the cap
    p_frame_cap_r5: assert property (@(posedge clk) disable iff (rst)
        int'(fcnt) <= FRAME_MAX);

    // R7: a finished frame always comes with a consumed buffer
    p_txf_with_txb_r7: assert property (@(posedge clk) disable iff (rst)
        ev_txf |-> ev_txb);

    // R7: a start marker only opens a fresh burst
    p_sof_first_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_sof) |-> !$past(out_valid));

    // R11: stream beats only inside a walk
    p_stream_busy_r11: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> busy);

endmodule

// File: tb/txbd_walker_tb_top.sv
module txbd_walker_tb_top;

    localparam int FMAX  = 40;
    localparam int DMAX  = 4;
    localparam logic [15:0] RDY = 16'h8000;
    localparam logic [15:0] WRP = 16'h2000;
    localparam logic [15:0] LST = 16'h0800;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic        kick = 1'b0;
    logic        base_wr = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        busy, mem_req, mem_we, mem_ack;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic        out_valid, out_sof, out_eof, ev_txb, ev_txf, ev_babble;
    logic [7:0]  out_data;

    logic [31:0] mem [256];
    int n_cmp = 0;
    int n_bad = 0;
    int req_n, txb_n, txf_n, bab_n, rx_n, sof_n, eof_n, eof_at;
    logic [7:0] rx [64];

    always #4 clk = ~clk;

    txbd_walker #(.FRAME_MAX(FMAX), .MAX_DESC(DMAX)) dut_i (
        .clk(clk), .rst(rst), .enable(enable), .kick(kick),
        .base_wr(base_wr), .base_wdata(base_wdata), .busy(busy),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof),
        .out_eof(out_eof), .ev_txb(ev_txb), .ev_txf(ev_txf),
        .ev_babble(ev_babble)
    );

    // Memory model: one acknowledged access per two cycles
    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end else begin
            mem_ack <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_ack) req_n++;
            if (ev_txb) txb_n++;
            if (ev_txf) txf_n++;
            if (ev_babble) bab_n++;
            if (out_valid) begin
                if (rx_n < 64) rx[rx_n] = out_data;
                if (out_sof) sof_n++;
                if (out_eof) begin eof_n++; eof_at = rx_n; end
                rx_n++;
            end
        end
    end

    function automatic logic [7:0] pat(input int a);
        return 8'(a ^ (a >> 8) ^ 'h5A);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clr_mon();
        req_n = 0; txb_n = 0; txf_n = 0; bab_n = 0;
        rx_n = 0; sof_n = 0; eof_n = 0; eof_at = -1;
    endtask

    task automatic chk_seg(input string req, input int idx0, input int addr, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            if (rx[idx0 + i] != pat(addr + i)) bad++;
        end
        chk(req, "byte mismatches", bad, 0);
    endtask

    task automatic set_desc(input int w, input logic [15:0] fl, input int len, input int ba);
        mem[w]     = {fl, 16'(len)};
        mem[w + 1] = ba;
    endtask

    task automatic clear_descs();
        for (int w = 0; w < 128; w++) mem[w] = '0;
    endtask

    task automatic write_base(input int ba);
        @(negedge clk); base_wr = 1'b1; base_wdata = ba;
        @(negedge clk); base_wr = 1'b0;
    endtask

    task automatic pulse_kick();
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
    endtask

    task automatic wait_idle();
        int q = 0;
        while (q < 3) begin
            @(negedge clk);
            if (busy) q = 0; else q++;
        end
    endtask

    task automatic t_reset();
        chk("R11", "busy after reset", int'(busy), 0);
        chk("R7", "stream valid after reset", int'(out_valid), 0);
        chk("R1", "mem_req after reset", int'(mem_req), 0);
    endtask

    task automatic t_disabled();
        clear_descs();
        set_desc(0, RDY | LST, 3, 'h200);
        clr_mon();
        enable = 1'b0;
        pulse_kick();
        repeat (10) @(negedge clk);
        chk("R1", "accesses on disabled kick", req_n, 0);
        chk("R1", "busy on disabled kick", int'(busy), 0);
        chk("R1", "descriptor untouched", int'(mem[0] == {RDY | LST, 16'd3}), 1);
        enable = 1'b1;
    endtask

    task automatic t_single_resume();
        clear_descs();
        write_base('h40);
        set_desc('h10, RDY | LST, 5, 'h201);
        clr_mon();
        pulse_kick();
        chk("R11", "busy after kick", int'(busy), 1);
        wait_idle();
        chk("R7", "frame length", rx_n, 5);
        chk_seg("R2", 0, 'h201, 5);
        chk("R7", "txb pulses", txb_n, 1);
        chk("R7", "txf pulses", txf_n, 1);
        chk("R7", "sof count", sof_n, 1);
        chk("R7", "eof position", eof_at, 4);
        chk("R6", "header written back", int'(mem['h10] == {LST, 16'd5}), 1);
        chk("R6", "address word intact", int'(mem['h11] == 32'h201), 1);
        set_desc('h12, RDY | LST, 2, 'h240);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R3", "resume frame length", rx_n, 2);
        chk_seg("R3", 0, 'h240, 2);
    endtask

    task automatic t_multi_wrap();
        clear_descs();
        write_base('h80);
        set_desc('h20, RDY, 3, 'h210);
        set_desc('h22, RDY, 4, 'h223);
        set_desc('h24, RDY | WRP | LST, 2, 'h231);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R7", "gathered length", rx_n, 9);
        chk_seg("R2", 0, 'h210, 3);
        chk_seg("R2", 3, 'h223, 4);
        chk_seg("R2", 7, 'h231, 2);
        chk("R7", "txb over three buffers", txb_n, 3);
        chk("R7", "single txf", txf_n, 1);
        set_desc('h20, RDY | LST, 1, 'h250);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R4", "wrap returned to base", rx_n, 1);
        chk_seg("R4", 0, 'h250, 1);
    endtask

    task automatic t_truncate();
        clear_descs();
        write_base('h100);
        set_desc('h40, RDY, 30, 'h260);
        set_desc('h42, RDY | LST, 20, 'h2A0);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R5", "capped length", rx_n, FMAX);
        chk("R5", "babble pulses", bab_n, 1);
        chk_seg("R5", 0, 'h260, 30);
        chk_seg("R5", 30, 'h2A0, 10);
        chk("R6", "length kept on truncation", int'(mem['h42] == {LST, 16'd20}), 1);
    endtask

    task automatic t_limit();
        clear_descs();
        write_base('h0);
        for (int i = 0; i < 6; i++) set_desc(2 * i, RDY | LST, 1, 'h300 + i);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R8", "frames in first walk", txf_n, DMAX);
        chk("R8", "fifth still owned", int'(mem[8][31]), 1);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R8", "frames in second walk", txf_n, 2);
        chk_seg("R8", 0, 'h304, 2);
    endtask

    task automatic t_pending();
        clear_descs();
        write_base('h0);
        for (int i = 0; i < 6; i++) set_desc(2 * i, RDY | LST, 1, 'h300 + i);
        clr_mon();
        pulse_kick();
        repeat (3) @(negedge clk);
        pulse_kick();
        wait_idle();
        chk("R10", "frames from queued kick", txf_n, 6);
        chk("R11", "busy after stop", int'(busy), 0);
    endtask

    task automatic t_base_busy();
        clear_descs();
        write_base('h20);
        set_desc(8, RDY | WRP | LST, 2, 'h310);
        set_desc('h30, RDY | LST, 1, 'h320);
        clr_mon();
        pulse_kick();
        write_base('hC0);
        wait_idle();
        chk("R9", "frames with base write ignored", txf_n, 1);
        set_desc(8, RDY | LST, 1, 'h330);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R9", "resume at old base", rx_n, 1);
        chk_seg("R9", 0, 'h330, 1);
    endtask

    task automatic t_partial_zero();
        clear_descs();
        write_base('h180);
        set_desc('h60, RDY, 3, 'h340);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R12", "open frame not streamed", rx_n, 0);
        chk("R12", "txb for open frame", txb_n, 1);
        set_desc('h62, RDY | LST, 2, 'h350);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R12", "fresh frame length", rx_n, 2);
        chk_seg("R12", 0, 'h350, 2);
        set_desc('h64, RDY | LST, 0, 'h360);
        clr_mon();
        pulse_kick();
        wait_idle();
        chk("R7", "empty frame txf", txf_n, 1);
        chk("R7", "empty frame beats", rx_n, 0);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int w = 0; w < 256; w++)
            mem[w] = {pat(4 * w), pat(4 * w + 1), pat(4 * w + 2), pat(4 * w + 3)};
        clr_mon();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_single_resume();
        t_multi_wrap();
        t_truncate();
        t_limit();
        t_pending();
        t_base_busy();
        t_partial_zero();
        summary();
        $finish;
    end

endmodule